// File: doc/BRIEF.md
# UART Receive Queue with Line Status

This block holds received characters for a UART receiver between the serial deserializer and the host. Each arriving byte enters a 64-entry first-in first-out store together with three error flags: parity, framing and break. The host sees the oldest byte, the head, on a read-data port. It removes that byte with a pop strobe. The block derives the receive-side line status bits from its state:
- a data-present bit;
- a sticky overrun bit;
- the error flags of the head byte;
- a summary bit that is high while any stored byte carries an error.

A fill-level comparator raises a trigger flag once the number of stored bytes reaches one of four programmable thresholds. An interrupt controller can use that flag to decide when to service the receiver.

When the queue is disabled the block acts as a single holding register: it stores one byte and reports on that byte. Changing the enable input empties the store. A byte that arrives while the store is full is dropped, the stored bytes are kept, and the overrun bit is set. The overrun bit stays set until the host reads the status.

Top module: `rx_fifo_status`

## Requirements
- R1: `data_ready` rises in the cycle after a byte is accepted into an empty store. It stays high until the last stored byte has been popped.
- R2: With `fifo_en`=1 the store holds up to 64 bytes in arrival order. `fill_count` gives the number stored. `rd_byte` shows the oldest byte before it is popped. A pop while empty has no effect.
- R3: The bits `head_perr`, `head_ferr` and `head_brk` give the flags stored with the oldest byte. While the store is empty, they and `rd_byte` are 0.
- R4: A byte that arrives while the store is full, with no pop in the same cycle, is discarded. The stored bytes and the count stay unchanged and `overrun` is set. A byte that arrives while full together with a pop is accepted.
- R5: `overrun` clears in the cycle after a `status_rd` strobe. If a new overrun occurs in the same cycle as `status_rd`, `overrun` stays set.
- R6: `any_err` is high while at least one stored byte has a parity, framing or break flag. It follows pops and goes low once no stored byte is flagged.
- R7: With `fifo_en`=1, `trig_hit` is high exactly while `fill_count` is at least the threshold chosen by `trig_sel`. The encodings are 0 for 8, 1 for 16, 2 for 56 and 3 for 60.
- R8: With `fifo_en`=0 the store holds at most one byte and a second byte causes an overrun as in R4. In this mode `trig_hit` follows `data_ready`.
- R9: A change of `fifo_en` empties the store in the following cycle, so `fill_count` and `any_err` go to 0. Pushes and pops in the cycle of the change are ignored. `overrun` is not affected by the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_en | input | 1 | 1 = 64-entry queue, 0 = single holding register |
| trig_sel | input | 2 | Trigger threshold select |
| rx_valid | input | 1 | Byte arrival strobe from the shift register |
| rx_byte | input | 8 | Arriving byte |
| rx_perr | input | 1 | Parity error of the arriving byte |
| rx_ferr | input | 1 | Framing error of the arriving byte |
| rx_brk | input | 1 | Break condition of the arriving byte |
| host_pop | input | 1 | Host reads and removes the head byte |
| status_rd | input | 1 | Host reads the line status (clears overrun) |
| rd_byte | output | 8 | Head byte |
| data_ready | output | 1 | At least one byte stored |
| overrun | output | 1 | Sticky overrun flag |
| head_perr | output | 1 | Parity error of head byte |
| head_ferr | output | 1 | Framing error of head byte |
| head_brk | output | 1 | Break flag of head byte |
| any_err | output | 1 | Some stored byte carries an error |
| trig_hit | output | 1 | Fill level at or above threshold |
| fill_count | output | 7 | Number of stored bytes |

## Verification
The assertions assume that `fifo_en` is a level which software changes only rarely. They assume nothing about the strobes: `rx_valid` and `host_pop` may arrive together, in any cycle and at any fill level, and the overrun and flush properties qualify on the internal flush condition. The stimulus keeps `fifo_en` steady while it fills and drains the store. It toggles `fifo_en` only in dedicated cycles with no strobes, except for one deliberate check that strobes in the change cycle are ignored.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    typedef struct packed {
        logic       brk;
        logic       ferr;
        logic       perr;
        logic [7:0] data;
    } rxf_entry_t;
endpackage

// File: rtl/rxf_store.sv
module rxf_store
    import rxf_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  rxf_entry_t      wentry,
    input  logic [AW-1:0]   raddr,
    output rxf_entry_t      rentry
);
    rxf_entry_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wentry;
        end
    end

    assign rentry = mem_q[raddr];
endmodule

// File: rtl/rxf_level.sv
module rxf_level #(
    parameter int DEPTH = 64,
    parameter int LVL0  = 8,
    parameter int LVL1  = 16,
    parameter int LVL2  = 56,
    parameter int LVL3  = 60,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          fifo_en,
    input  logic [1:0]    sel,
    input  logic [CW-1:0] fill,
    output logic          hit
);
    logic [CW-1:0] thresh;

    always_comb begin
        unique case (sel)
            2'd0:    thresh = CW'(LVL0);
            2'd1:    thresh = CW'(LVL1);
            2'd2:    thresh = CW'(LVL2);
            default: thresh = CW'(LVL3);
        endcase
        if (!fifo_en) begin
            thresh = CW'(1);
        end
        hit = (fill >= thresh);
    end
endmodule

// File: rtl/rx_fifo_status.sv
module rx_fifo_status
    import rxf_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int LVL0  = 8,
    parameter int LVL1  = 16,
    parameter int LVL2  = 56,
    parameter int LVL3  = 60,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic [1:0]    trig_sel,
    input  logic          rx_valid,
    input  logic [7:0]    rx_byte,
    input  logic          rx_perr,
    input  logic          rx_ferr,
    input  logic          rx_brk,
    input  logic          host_pop,
    input  logic          status_rd,
    output logic [7:0]    rd_byte,
    output logic          data_ready,
    output logic          overrun,
    output logic          head_perr,
    output logic          head_ferr,
    output logic          head_brk,
    output logic          any_err,
    output logic          trig_hit,
    output logic [CW-1:0] fill_count
);
    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] count;
        logic [CW-1:0] err_cnt;
        logic          ovr;
        logic          en;
    } state_t;

    state_t     s_d, s_q;
    rxf_entry_t head, wentry;
    logic       flush, empty, do_pop, do_push, head_err, in_err;
    logic [CW-1:0] cap;

    assign wentry = '{brk: rx_brk, ferr: rx_ferr, perr: rx_perr, data: rx_byte};

    rxf_store #(.DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .we     (do_push),
        .waddr  (s_q.wr_ptr),
        .wentry (wentry),
        .raddr  (s_q.rd_ptr),
        .rentry (head)
    );

    rxf_level #(
        .DEPTH(DEPTH), .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)
    ) u_level (
        .fifo_en (fifo_en),
        .sel     (trig_sel),
        .fill    (s_q.count),
        .hit     (trig_hit)
    );

    always_comb begin
        s_d      = s_q;
        flush    = (fifo_en != s_q.en);
        cap      = fifo_en ? CW'(DEPTH) : CW'(1);
        empty    = (s_q.count == '0);
        head_err = head.brk | head.ferr | head.perr;
        in_err   = rx_brk | rx_ferr | rx_perr;
        do_pop   = host_pop && !empty && !flush;
        do_push  = rx_valid && !flush && ((s_q.count < cap) || do_pop);
        s_d.en   = fifo_en;
        if (flush) begin
            s_d.wr_ptr  = '0;
            s_d.rd_ptr  = '0;
            s_d.count   = '0;
            s_d.err_cnt = '0;
        end else begin
            s_d.wr_ptr  = s_q.wr_ptr + AW'(do_push);
            s_d.rd_ptr  = s_q.rd_ptr + AW'(do_pop);
            s_d.count   = s_q.count + CW'(do_push) - CW'(do_pop);
            s_d.err_cnt = s_q.err_cnt + CW'(do_push && in_err)
                                      - CW'(do_pop && head_err);
        end
        if (rx_valid && !flush && !do_push) begin
            s_d.ovr = 1'b1;
        end else if (status_rd) begin
            s_d.ovr = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{wr_ptr: '0, rd_ptr: '0, count: '0, err_cnt: '0,
                     ovr: 1'b0, en: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    assign data_ready = !empty;
    assign overrun    = s_q.ovr;
    assign fill_count = s_q.count;
    assign any_err    = (s_q.err_cnt != '0);
    assign rd_byte    = empty ? 8'h00 : head.data;
    assign head_perr  = !empty && head.perr;
    assign head_ferr  = !empty && head.ferr;
    assign head_brk   = !empty && head.brk;
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_en,
    input logic          flush,
    input logic          rx_valid,
    input logic          rx_perr,
    input logic          rx_ferr,
    input logic          rx_brk,
    input logic          host_pop,
    input logic [7:0]    rd_byte,
    input logic          data_ready,
    input logic          overrun,
    input logic          head_perr,
    input logic          head_ferr,
    input logic          head_brk,
    input logic          any_err,
    input logic [CW-1:0] fill_count
);
    logic [CW-1:0] cap;
    assign cap = fifo_en ? CW'(DEPTH) : CW'(1);

    assert_fill_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= CW'(DEPTH));

    assert_ready_on_push_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !flush && fill_count == '0) |=> data_ready);

    assert_empty_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !data_ready |-> (!head_perr && !head_ferr && !head_brk && rd_byte == 8'h00));

    assert_overrun_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !host_pop && !flush && fill_count == cap) |=> overrun);

    assert_overrun_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !host_pop && !flush && fill_count == cap) |=> $stable(fill_count));

    assert_no_err_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_err && !(rx_valid && (rx_perr || rx_ferr || rx_brk))) |=> !any_err);

    assert_holding_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && !flush) |-> fill_count <= CW'(1));

    assert_flush_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (fill_count == '0 && !any_err));
endmodule

bind rx_fifo_status rxf_checker #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_en    (fifo_en),
    .flush      (flush),
    .rx_valid   (rx_valid),
    .rx_perr    (rx_perr),
    .rx_ferr    (rx_ferr),
    .rx_brk     (rx_brk),
    .host_pop   (host_pop),
    .rd_byte    (rd_byte),
    .data_ready (data_ready),
    .overrun    (overrun),
    .head_perr  (head_perr),
    .head_ferr  (head_ferr),
    .head_brk   (head_brk),
    .any_err    (any_err),
    .fill_count (fill_count)
);

// File: tb/rx_fifo_status_test.sv
module rx_fifo_status_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b1;
    logic [1:0] trig_sel = 2'd0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       rx_perr = 1'b0, rx_ferr = 1'b0, rx_brk = 1'b0;
    logic       host_pop = 1'b0, status_rd = 1'b0;
    logic [7:0] rd_byte;
    logic       data_ready, overrun, head_perr, head_ferr, head_brk, any_err, trig_hit;
    logic [6:0] fill_count;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // model: {brk, ferr, perr, data}
    logic [10:0] mq[$];
    bit m_ovr = 1'b0;

    always #10 clk = ~clk;

    rx_fifo_status uut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_sel(trig_sel),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_perr(rx_perr),
        .rx_ferr(rx_ferr), .rx_brk(rx_brk), .host_pop(host_pop),
        .status_rd(status_rd), .rd_byte(rd_byte), .data_ready(data_ready),
        .overrun(overrun), .head_perr(head_perr), .head_ferr(head_ferr),
        .head_brk(head_brk), .any_err(any_err), .trig_hit(trig_hit),
        .fill_count(fill_count)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int level_of(input bit en, input logic [1:0] s);
        if (!en) return 1;
        case (s)
            2'd0: return 8;
            2'd1: return 16;
            2'd2: return 56;
            default: return 60;
        endcase
    endfunction

    function automatic bit model_any_err();
        foreach (mq[i]) if (mq[i][10:8] != 3'b000) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check_all();
        int n = mq.size();
        int lv = level_of(fifo_en, trig_sel);
        chk(fill_count == 7'(n), "R2 fill_count", fill_count, n);
        chk(data_ready == (n > 0), "R1 data_ready", data_ready, int'(n > 0));
        chk(overrun == m_ovr, "R4/R5 overrun", overrun, m_ovr);
        chk(any_err == model_any_err(), "R6 any_err", any_err, model_any_err());
        chk(trig_hit == (n >= lv), fifo_en ? "R7 trig_hit" : "R8 trig_hit",
            trig_hit, int'(n >= lv));
        if (n > 0) begin
            chk(rd_byte == mq[0][7:0], "R2 rd_byte head", rd_byte, mq[0][7:0]);
            chk({head_brk, head_ferr, head_perr} == mq[0][10:8], "R3 head flags",
                {head_brk, head_ferr, head_perr}, mq[0][10:8]);
        end else begin
            chk({rd_byte, head_brk, head_ferr, head_perr} == 11'd0, "R3 empty head",
                {rd_byte, head_brk, head_ferr, head_perr}, 0);
        end
    endtask

    // One clock with the given strobes; the model follows the requirements.
    task automatic step(input bit push, input logic [7:0] d, input logic [2:0] e,
                        input bit pop, input bit srd);
        int cap = fifo_en ? 64 : 1;
        bit popped, accepted;
        rx_valid = push; rx_byte = d; {rx_brk, rx_ferr, rx_perr} = e;
        host_pop = pop; status_rd = srd;
        @(posedge clk);
        #2;
        rx_valid = 1'b0; host_pop = 1'b0; status_rd = 1'b0;
        {rx_brk, rx_ferr, rx_perr} = 3'b000;
        popped   = pop && mq.size() > 0;
        accepted = push && (mq.size() < cap || popped);
        if (popped) void'(mq.pop_front());
        if (accepted) mq.push_back({e, d});
        if (push && !accepted) m_ovr = 1'b1;
        else if (srd) m_ovr = 1'b0;
        check_all();
    endtask

    task automatic set_mode(input bit en, input bit strobe);
        fifo_en = en;
        rx_valid = strobe; host_pop = strobe; rx_byte = 8'hEE;
        @(posedge clk);
        #2;
        rx_valid = 1'b0; host_pop = 1'b0;
        mq.delete();
        chk(fill_count == 0, "R9 flush count", fill_count, 0);
        chk(any_err == 1'b0, "R9 flush any_err", any_err, 0);
        check_all();
    endtask

    function automatic logic [2:0] err_pat(input int i);
        return {3'(i % 13 == 9), 3'(i % 11 == 5) << 1 | 3'(i % 7 == 3)} & 3'b111;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // reset state: R1 R3 R4 R6 R7
        check_all();

        for (int s = 0; s < 4; s++) begin
            trig_sel = 2'(s);
            #1;
            for (int i = 0; i < 64; i++) begin
                step(1'b1, 8'(i * 5 + s), {(i % 13 == 9), (i % 11 == 5), (i % 7 == 3)},
                     1'b0, 1'b0);
            end
            // R4: push while full is dropped
            step(1'b1, 8'hA5, 3'b111, 1'b0, 1'b0);
            // R5: new overrun with status read keeps overrun set
            step(1'b1, 8'h5A, 3'b000, 1'b0, 1'b1);
            // R5: status read clears
            step(1'b0, 8'h00, 3'b000, 1'b0, 1'b1);
            // R4: push with pop while full is accepted
            step(1'b1, 8'hC3, 3'b010, 1'b1, 1'b0);
            // R2/R3/R6: drain with head checks at each pop, one extra pop on empty
            for (int i = 0; i < 65; i++) begin
                step(1'b0, 8'h00, 3'b000, 1'b1, 1'b0);
            end
        end

        // R9: flush with stored flagged bytes, overrun kept
        for (int i = 0; i < 5; i++) step(1'b1, 8'(i + 100), 3'b001, 1'b0, 1'b0);
        m_ovr = 1'b0;
        set_mode(1'b0, 1'b1);
        // R8: holding register
        step(1'b1, 8'h11, 3'b100, 1'b0, 1'b0);
        step(1'b1, 8'h22, 3'b000, 1'b0, 1'b0);
        chk(rd_byte == 8'h11, "R8 held byte kept", rd_byte, 8'h11);
        step(1'b1, 8'h33, 3'b010, 1'b1, 1'b0);
        step(1'b0, 8'h00, 3'b000, 1'b0, 1'b1);
        step(1'b0, 8'h00, 3'b000, 1'b1, 1'b0);
        step(1'b1, 8'h44, 3'b000, 1'b0, 1'b0);
        // R9: back to queue mode empties the holding register
        set_mode(1'b1, 1'b0);
        for (int i = 0; i < 20; i++) step(1'b1, 8'(i), err_pat(i), (i % 3 == 2), 1'b0);
        for (int i = 0; i < 16; i++) step(1'b0, 8'h00, 3'b000, 1'b1, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule